// File: doc/BRIEF.md
# Interleaved Block Memory Controller

This block models the memory side of a cache-line fill. A requester presents a block address and pulses a start strobe. The block then returns the words of that block one per cycle over a bus that is one word wide. Each word comes with a valid strobe, and a done flag rides on the last word. A write-block command follows the same timing. The write data for the whole block is captured when the request is accepted, and each word is echoed on the response bus in the cycle it is written.

With the default interleaved configuration, word `i` of every block lives in bank `i mod 4`. One address cycle starts all banks together, so one 15-cycle bank access is shared by the whole block. The four words then stream out in consecutive cycles, and a transfer takes 1 + 15 + 4 = 20 cycles. Setting `INTERLEAVED` to 0 builds a single narrow bank for comparison. Each word then needs its own 15-cycle access, and a transfer takes 1 + 4*15 + 4 = 65 cycles.

The sequencer has four named states. `ST_IDLE` waits for start. `ST_ADDR` is the one-cycle address phase. `ST_ACCESS` is the bank access of `ACCESS_LAT` cycles. `ST_XFER` drives one word per cycle. The transitions are: start while idle (`ST_IDLE`->`ST_ADDR`); address sent (`ST_ADDR`->`ST_ACCESS`); access complete (`ST_ACCESS`->`ST_XFER`). From `ST_XFER`, the next word goes out in the same state in the interleaved build, or through a return to `ST_ACCESS` for the next access in the single-bank build. After the last word the sequencer returns to `ST_IDLE`.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset `rsp_valid`, `rsp_done` and `busy` are all 0.
- R2: When the block is idle and `req_start` is 1 at a clock edge, the request is accepted at that edge (call it edge 0). `busy` is 1 from the cycle after edge 0 until the done cycle, and it is 0 in the cycle after the done cycle.
- R3: Interleaved build, counting sampled cycles from 1 after edge 0: `rsp_valid` is 1 in cycles 17, 18, 19 and 20 and at no other time, and `rsp_done` is 1 only in cycle 20. A transfer therefore takes 20 cycles.
- R4: Single-bank build (`INTERLEAVED`=0): `rsp_valid` is 1 only in cycles 17, 33, 49 and 65, and `rsp_done` is 1 only in cycle 65. A transfer therefore takes 65 cycles.
- R5: Words are returned in ascending offset order, and each word carries its block offset. On a read, the word at offset `i` equals bits `[32*i+31:32*i]` of the `wr_block` last written to that block address. In the interleaved build that word is stored in bank `i mod 4`.
- R6: A write-block command (`req_write`=1 at acceptance) has the same valid and done timing as a read in the same build. On each valid cycle `rsp_data` echoes the word being written.
- R7: `req_start` while `busy` is 1 is ignored, including in the done cycle. The block address, command and data of the current transfer are not altered, and no extra transfer begins.
- R8: During a transfer `rsp_done` is 1 exactly once, and only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start strobe; taken only when idle |
| req_write | input | 1 | 1 = write block, 0 = read block |
| req_blk_addr | input | ADDR_W | Block address |
| wr_block | input | WORDS*WORD_W | Write data, word i in bits [WORD_W*i +: WORD_W] |
| rsp_valid | output | 1 | A word is on `rsp_data` this cycle |
| rsp_data | output | WORD_W | Returned or echoed word |
| rsp_done | output | 1 | Last word of the transfer |
| busy | output | 1 | A transfer is in progress |

## Verification
Two events can fall in the same cycle: a new start strobe and the done pulse of the running transfer. The bench raises `req_start`, with a different address and a write command, exactly in the interleaved build's done cycle (20). It also raises it mid-access (cycle 8). It then judges that `busy` drops in cycle 21 and that the timing of both builds is unchanged. A later read sweep of every block must return the originally written data, which shows that the stray write never happened.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER
    } ilv_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 256,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Row contents are settled once the access window has elapsed
    assign rdata = mem[addr];
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int WORDS       = 4,
    parameter int ACCESS_LAT  = 15,
    parameter bit INTERLEAVED = 1'b1,
    localparam int WI_W       = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LAT_W      = $clog2(ACCESS_LAT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            accept,
    output logic            busy,
    output logic            xfer_valid,
    output logic            xfer_last,
    output logic [WI_W-1:0] word_idx
);
    localparam logic [LAT_W-1:0] LAT_LAST  = LAT_W'(ACCESS_LAT - 1);
    localparam logic [WI_W-1:0]  WORD_LAST = WI_W'(WORDS - 1);

    ilv_state_e       state, state_n;
    logic [LAT_W-1:0] lat_cnt, lat_n;
    logic [WI_W-1:0]  word_cnt, word_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_cnt  <= '0;
            word_cnt <= '0;
        end else begin
            state    <= state_n;
            lat_cnt  <= lat_n;
            word_cnt <= word_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state;
        lat_n   = lat_cnt;
        word_n  = word_cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_ADDR;
                    word_n  = '0;
                end
            end
            ST_ADDR: begin
                state_n = ST_ACCESS;
                lat_n   = '0;
            end
            ST_ACCESS: begin
                if (lat_cnt == LAT_LAST) begin
                    state_n = ST_XFER;
                end else begin
                    lat_n = lat_cnt + 1'b1;
                end
            end
            ST_XFER: begin
                if (word_cnt == WORD_LAST) begin
                    state_n = ST_IDLE;
                end else begin
                    word_n = word_cnt + 1'b1;
                    if (!INTERLEAVED) begin
                        state_n = ST_ACCESS;
                        lat_n   = '0;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept     = (state == ST_IDLE) && start;
        busy       = (state != ST_IDLE);
        xfer_valid = (state == ST_XFER);
        xfer_last  = (state == ST_XFER) && (word_cnt == WORD_LAST);
        word_idx   = word_cnt;
    end

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !xfer_valid));
    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |=> !busy);
    a_r7_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !xfer_last) |=> busy);
    a_r8_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |-> xfer_valid);
    a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (INTERLEAVED && xfer_valid && !xfer_last) |=> (xfer_valid && word_idx == $past(word_idx) + 1'b1));
    a_r4_spaced_words: assert property (@(posedge clk) disable iff (!rst_n)
        (!INTERLEAVED && xfer_valid && !xfer_last) |=> !xfer_valid);
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl #(
    parameter int WORD_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int WORDS       = 4,
    parameter int NUM_BANKS   = 4,
    parameter int ACCESS_LAT  = 15,
    parameter bit INTERLEAVED = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_start,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_blk_addr,
    input  logic [WORDS*WORD_W-1:0] wr_block,
    output logic                    rsp_valid,
    output logic [WORD_W-1:0]       rsp_data,
    output logic                    rsp_done,
    output logic                    busy
);
    localparam int NB_EFF       = INTERLEAVED ? NUM_BANKS : 1;
    localparam int ROWS_PER_BLK = WORDS / NB_EFF;
    localparam int BANK_DEPTH   = (2 ** ADDR_W) * ROWS_PER_BLK;
    localparam int ROW_W        = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
    localparam int WI_W         = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BSEL_W       = (NB_EFF > 1) ? $clog2(NB_EFF) : 1;

    logic                    accept, xfer_valid, xfer_last;
    logic [WI_W-1:0]         word_idx;
    logic [ADDR_W-1:0]       blk_q;
    logic                    wr_q;
    logic [WORDS*WORD_W-1:0] wdata_q;
    logic [ROW_W-1:0]        row;
    logic [BSEL_W-1:0]       bsel;
    logic [WORD_W-1:0]       wr_word;
    logic [WORD_W-1:0]       rd_word;
    logic [WORD_W-1:0]       rd_all [NB_EFF];

    ilv_seq #(
        .WORDS      (WORDS),
        .ACCESS_LAT (ACCESS_LAT),
        .INTERLEAVED(INTERLEAVED)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_start),
        .accept    (accept),
        .busy      (busy),
        .xfer_valid(xfer_valid),
        .xfer_last (xfer_last),
        .word_idx  (word_idx)
    );

    // Request capture: only on acceptance, so a start while busy changes nothing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            blk_q   <= req_blk_addr;
            wr_q    <= req_write;
            wdata_q <= wr_block;
        end
    end

    // Word i goes to bank (i mod banks), row = block * rows-per-block + i / banks
    always_comb begin
        row     = ROW_W'(blk_q) * ROW_W'(ROWS_PER_BLK) + ROW_W'(word_idx / NB_EFF);
        bsel    = BSEL_W'(word_idx % NB_EFF);
        wr_word = wdata_q[word_idx*WORD_W +: WORD_W];
    end

    for (genvar b = 0; b < NB_EFF; b++) begin : g_bank
        ilv_bank #(
            .WORD_W(WORD_W),
            .DEPTH (BANK_DEPTH)
        ) bank_i (
            .clk  (clk),
            .we   (wr_q && xfer_valid && (bsel == BSEL_W'(b))),
            .addr (row),
            .wdata(wr_word),
            .rdata(rd_all[b])
        );
    end

    if (NB_EFF == 1) begin : g_one
        assign rd_word = rd_all[0];
    end else begin : g_many
        assign rd_word = rd_all[bsel];
    end

    always_comb begin
        rsp_valid = xfer_valid;
        rsp_done  = xfer_last;
        rsp_data  = xfer_valid ? (wr_q ? wr_word : rd_word) : '0;
    end

    a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wdata_q) && $stable(blk_q) && $stable(wr_q)));
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rsp_valid && !rsp_done));
endmodule

// File: tb/ilv_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module ilv_mem_ctrl_tb_top;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int WORDS  = 4;
    localparam int LAT    = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_blk_addr = '0;
    logic [WORDS*WORD_W-1:0] wr_block = '0;
    logic v_i, d_i, b_i, v_s, d_s, b_s;
    logic [WORD_W-1:0] q_i, q_s;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ilv_mem_ctrl #(.INTERLEAVED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_blk_addr(req_blk_addr), .wr_block(wr_block),
        .rsp_valid(v_i), .rsp_data(q_i), .rsp_done(d_i), .busy(b_i));

    ilv_mem_ctrl #(.INTERLEAVED(1'b0)) dut_s (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_blk_addr(req_blk_addr), .wr_block(wr_block),
        .rsp_valid(v_s), .rsp_data(q_s), .rsp_done(d_s), .busy(b_s));

    function automatic logic [WORD_W-1:0] pat(input int a, input int i);
        return {a[7:0], i[7:0], 16'h5C3A ^ a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input bit wr, input int a, input int ign_at);
        int nv_i = 0, nv_s = 0, done_i = 0, done_s = 0, nd_i = 0, nd_s = 0;
        bit busy21 = 1'b0, busy1 = 1'b0;
        @(negedge clk);
        req_start = 1'b1;
        req_write = wr;
        req_blk_addr = ADDR_W'(a);
        for (int w = 0; w < WORDS; w++) wr_block[w*WORD_W +: WORD_W] = pat(a, w);
        for (int n = 1; n <= 70; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_start = 1'b0;
                busy1 = b_i & b_s;
                // scramble inputs: must have no effect after acceptance
                req_blk_addr = ~ADDR_W'(a);
                wr_block = ~wr_block;
            end
            if (n == 21) busy21 = b_i;
            if (v_i) begin
                // R3: interleaved words in cycles 17..20
                chk(n == 17 + nv_i, "R3 interleaved word cycle", n, 17 + nv_i);
                chk(q_i == pat(a, nv_i), wr ? "R6 interleaved write echo" : "R5 interleaved read data", q_i, pat(a, nv_i));
                nv_i++;
            end
            if (v_s) begin
                // R4: single-bank words at 17 + 16*j
                chk(n == 17 + 16 * nv_s, "R4 single word cycle", n, 17 + 16 * nv_s);
                chk(q_s == pat(a, nv_s), wr ? "R6 single write echo" : "R5 single read data", q_s, pat(a, nv_s));
                nv_s++;
            end
            if (d_i) begin done_i = n; nd_i++; chk(v_i, "R8 done with valid (interleaved)", v_i, 1); end
            if (d_s) begin done_s = n; nd_s++; chk(v_s, "R8 done with valid (single)", v_s, 1); end
            if (n == ign_at || n == 8 && ign_at != 0) begin
                req_start = 1'b1;          // R7: stray start while busy
                req_write = 1'b1;
                req_blk_addr = ADDR_W'(a + 1);
            end else begin
                req_start = 1'b0;
                req_write = 1'b0;
            end
        end
        chk(nv_i == WORDS, "R3 interleaved word count", nv_i, WORDS);
        chk(nv_s == WORDS, "R4 single word count", nv_s, WORDS);
        chk(done_i == 1 + LAT + WORDS, "R3 interleaved transfer cycles", done_i, 1 + LAT + WORDS);
        chk(done_s == 1 + WORDS * LAT + WORDS, "R4 single transfer cycles", done_s, 1 + WORDS * LAT + WORDS);
        chk(nd_i == 1 && nd_s == 1, "R8 one done per transfer", nd_i + nd_s, 2);
        chk(busy1, "R2 busy after accept", busy1, 1);
        chk(!busy21, "R2 R7 idle after done despite start in done cycle", busy21, 0);
        chk(!b_s && !b_i, "R7 no extra transfer started", b_i | b_s, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!v_i && !d_i && !b_i, "R1 interleaved reset state", {v_i, d_i, b_i}, 0);
        chk(!v_s && !d_s && !b_s, "R1 single reset state", {v_s, d_s, b_s}, 0);
        rst_n = 1'b1;
        // Write every block, then read every block back
        for (int a = 0; a < (1 << ADDR_W); a++) run(1'b1, a, (a % 16 == 5) ? 20 : 0);
        for (int a = 0; a < (1 << ADDR_W); a++) run(1'b0, a, (a % 16 == 9) ? 20 : 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end
endmodule